// File: doc/BRIEF.md
# Inclusion Policy Selector for a Shared Last-Level Cache

This block chooses, at run time, whether a shared last-level cache behaves non-inclusively or exclusively with respect to the private caches above it. It does this by set dueling. Two small groups of sampling sets are pinned, one to each policy. Every other set is a follower and takes whichever policy won the last epoch. For each group the block counts misses and insertions. At the end of every epoch it compares the miss difference against a performance threshold to pick the mode. It then compares the insertion difference against an insertion threshold to pick the base or extended variant of that mode. The extended variant is bypass in exclusive mode and aggressive fill in non-inclusive mode.

The decision logic is replicated once per core. Each event carries the core that caused it, so each application is judged on its own. A combinational lookup port tells the cache controller the policy and the extension flag that apply to any set for any core. Sampling sets are recognised by a fixed pattern on the low bits of the set index.

Top module: `incl_policy_sel`

## Requirements
- R1: While reset is asserted and after its release until the first epoch end, every core reports non-inclusive mode (mode_excl bit 0), with aggr_fill 0 and bypass 0.
- R2: A set whose low SMP_BITS index bits equal SMP_PAT (default 3'b010) is a non-inclusive sample. A set whose low bits equal ~SMP_PAT (default 3'b101) is an exclusive sample. All other sets are followers.
- R3: The lookup port reports lk_excl = 0 and lk_ext = 0 for a non-inclusive sample, and lk_excl = 1 and lk_ext = 0 for an exclusive sample. For a follower it reports lk_excl = mode_excl[lk_core], and lk_ext equal to that core's bypass bit when in exclusive mode or its aggr_fill bit when in non-inclusive mode.
- R4: A miss or insertion strobe on a follower set changes no counter and so has no effect on the next decision.
- R5: On an epoch end, a core's mode becomes 1 (exclusive) exactly when its non-inclusive-sample misses minus its exclusive-sample misses is strictly greater than perf_thr. Otherwise the mode becomes 0.
- R6: On an epoch end, let D be the exclusive-sample insertions minus the non-inclusive-sample insertions. In exclusive mode, bypass is set iff D > ins_thr. In non-inclusive mode, aggr_fill is set iff D <= ins_thr. The flag that does not belong to the chosen mode is 0.
- R7: mode_excl, aggr_fill and bypass change only on the clock edge where epoch_end is high. They hold their value at every other edge.
- R8: Each counter saturates at 2^CNT_W-1 and never wraps.
- R9: All counters clear on the epoch-end edge, after the decision is taken from their old values. A strobe in the same cycle as epoch_end is counted in neither epoch.
- R10: Events tagged with core c change only core c's counters and decision.
- R11: perf_thr and ins_thr are two's complement values of CNT_W+1 bits, compared against signed differences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_core | input | CORE_W | Core that caused the event |
| ev_set | input | SET_W | Set index of the event |
| ev_miss | input | 1 | Miss strobe |
| ev_ins | input | 1 | Last-level insertion strobe |
| epoch_end | input | 1 | One-cycle epoch boundary pulse |
| perf_thr | input | CNT_W+1 | Signed performance threshold |
| ins_thr | input | CNT_W+1 | Signed insertion threshold |
| mode_excl | output | NUM_CORES | Per-core mode, 1 = exclusive |
| aggr_fill | output | NUM_CORES | Per-core aggressive-fill flag |
| bypass | output | NUM_CORES | Per-core bypass flag |
| lk_core | input | CORE_W | Core for the policy lookup |
| lk_set | input | SET_W | Set index for the policy lookup |
| lk_excl | output | 1 | Policy for that set, 1 = exclusive |
| lk_ext | output | 1 | Extension flag for that set |

## Verification
The assertions assume that epoch_end is the only trigger for a decision. They also assume that the lookup inputs are driven to known values whenever reset is deasserted, so the sample-set lookup properties are meaningful on every edge. They assume the thresholds are stable around the epoch edge, which the bench guarantees by changing them only between epochs. The stimulus drives lk_core only below NUM_CORES. It biases the set index toward the two sampling patterns so that both groups accumulate counts.

// File: rtl/incl_sel_pkg.sv
package incl_sel_pkg;
  // Role of a set in the duel
  typedef enum logic [1:0] {
    SMP_FOLLOW = 2'd0,
    SMP_NONINC = 2'd1,
    SMP_EXCL   = 2'd2
  } smp_cls_e;

  // Latched decision of one core
  typedef struct packed {
    logic mode;   // 1 = exclusive
    logic aggr;   // aggressive fill (non-inclusive only)
    logic byp;    // bypass (exclusive only)
  } incl_dec_t;
endpackage

// File: rtl/incl_set_class.sv
module incl_set_class
  import incl_sel_pkg::*;
#(
  parameter int              SMP_BITS = 3,
  parameter logic [SMP_BITS-1:0] SMP_PAT = 3'b010
) (
  input  logic [SMP_BITS-1:0] set_lo,
  output smp_cls_e            cls
);
  always_comb begin
    if (set_lo == SMP_PAT)       cls = SMP_NONINC;
    else if (set_lo == ~SMP_PAT) cls = SMP_EXCL;
    else                         cls = SMP_FOLLOW;
  end
endmodule

// File: rtl/incl_sat_ctr.sv
module incl_sat_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt != CNT_MAX));
    cnt_d  = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/incl_policy_core.sv
module incl_policy_core
  import incl_sel_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int DW   = CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_hit,
  input  smp_cls_e             ev_cls,
  input  logic                 ev_miss,
  input  logic                 ev_ins,
  input  logic                 epoch_end,
  input  logic signed [DW-1:0] perf_thr,
  input  logic signed [DW-1:0] ins_thr,
  output incl_dec_t            dec_q
);
  // counter slots: 0 NI miss, 1 EX miss, 2 NI ins, 3 EX ins
  localparam int NCTR = 4;

  logic [NCTR-1:0]  inc;
  logic [CNT_W-1:0] cnt [NCTR];
  logic signed [DW-1:0] miss_diff, ins_diff;
  incl_dec_t dec_d;

  always_comb begin
    logic live;
    live   = ev_hit & ~epoch_end;
    inc[0] = live & ev_miss & (ev_cls == SMP_NONINC);
    inc[1] = live & ev_miss & (ev_cls == SMP_EXCL);
    inc[2] = live & ev_ins  & (ev_cls == SMP_NONINC);
    inc[3] = live & ev_ins  & (ev_cls == SMP_EXCL);
  end

  for (genvar k = 0; k < NCTR; k++) begin : g_ctr
    incl_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (epoch_end),
      .inc  (inc[k]),
      .cnt  (cnt[k])
    );
  end

  always_comb begin
    logic over;
    miss_diff  = $signed({1'b0, cnt[0]}) - $signed({1'b0, cnt[1]});
    ins_diff   = $signed({1'b0, cnt[3]}) - $signed({1'b0, cnt[2]});
    over       = ins_diff > ins_thr;
    dec_d.mode = miss_diff > perf_thr;
    dec_d.byp  = dec_d.mode & over;
    dec_d.aggr = ~dec_d.mode & ~over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dec_q <= '0;
    else if (epoch_end) dec_q <= dec_d;
  end
endmodule

// File: rtl/incl_policy_sel.sv
module incl_policy_sel
  import incl_sel_pkg::*;
#(
  parameter int                  NUM_CORES = 2,
  parameter int                  SET_W     = 10,
  parameter int                  SMP_BITS  = 3,
  parameter logic [SMP_BITS-1:0] SMP_PAT   = 3'b010,
  parameter int                  CNT_W     = 16,
  localparam int                 CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int                 DW        = CNT_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CORE_W-1:0]    ev_core,
  input  logic [SET_W-1:0]     ev_set,
  input  logic                 ev_miss,
  input  logic                 ev_ins,
  input  logic                 epoch_end,
  input  logic signed [DW-1:0] perf_thr,
  input  logic signed [DW-1:0] ins_thr,
  output logic [NUM_CORES-1:0] mode_excl,
  output logic [NUM_CORES-1:0] aggr_fill,
  output logic [NUM_CORES-1:0] bypass,
  input  logic [CORE_W-1:0]    lk_core,
  input  logic [SET_W-1:0]     lk_set,
  output logic                 lk_excl,
  output logic                 lk_ext
);
  smp_cls_e ev_cls, lk_cls;

  incl_set_class #(.SMP_BITS(SMP_BITS), .SMP_PAT(SMP_PAT)) u_ev_cls (
    .set_lo(ev_set[SMP_BITS-1:0]),
    .cls   (ev_cls)
  );

  incl_set_class #(.SMP_BITS(SMP_BITS), .SMP_PAT(SMP_PAT)) u_lk_cls (
    .set_lo(lk_set[SMP_BITS-1:0]),
    .cls   (lk_cls)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    incl_dec_t dec;
    logic      hit;
    assign hit = (ev_core == CORE_W'(c));

    incl_policy_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_hit   (hit),
      .ev_cls   (ev_cls),
      .ev_miss  (ev_miss),
      .ev_ins   (ev_ins),
      .epoch_end(epoch_end),
      .perf_thr (perf_thr),
      .ins_thr  (ins_thr),
      .dec_q    (dec)
    );

    assign mode_excl[c] = dec.mode;
    assign aggr_fill[c] = dec.aggr;
    assign bypass[c]    = dec.byp;
  end

  always_comb begin
    logic f_mode, f_ext;
    f_mode = mode_excl[lk_core];
    f_ext  = f_mode ? bypass[lk_core] : aggr_fill[lk_core];
    case (lk_cls)
      SMP_NONINC: begin lk_excl = 1'b0;   lk_ext = 1'b0;  end
      SMP_EXCL:   begin lk_excl = 1'b1;   lk_ext = 1'b0;  end
      default:    begin lk_excl = f_mode; lk_ext = f_ext; end
    endcase
  end
endmodule

// File: rtl/incl_policy_sel_chk.sv
module incl_policy_sel_chk #(
  parameter int                  NUM_CORES = 2,
  parameter int                  SET_W     = 10,
  parameter int                  SMP_BITS  = 3,
  parameter logic [SMP_BITS-1:0] SMP_PAT   = 3'b010
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 epoch_end,
  input logic [NUM_CORES-1:0] mode_excl,
  input logic [NUM_CORES-1:0] aggr_fill,
  input logic [NUM_CORES-1:0] bypass,
  input logic [SET_W-1:0]     lk_set,
  input logic                 lk_excl,
  input logic                 lk_ext
);
  // R7
  hold_between_epochs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(epoch_end) |-> $stable({mode_excl, aggr_fill, bypass}));

  // R6
  aggr_only_noninc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aggr_fill & mode_excl) == '0);

  // R6
  bypass_only_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass & ~mode_excl) == '0);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (mode_excl == '0) && (aggr_fill == '0) && (bypass == '0));

  // R3
  noninc_sample_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_set[SMP_BITS-1:0] == SMP_PAT) |-> (!lk_excl && !lk_ext));

  // R3
  excl_sample_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_set[SMP_BITS-1:0] == ~SMP_PAT) |-> (lk_excl && !lk_ext));
endmodule

bind incl_policy_sel incl_policy_sel_chk #(
  .NUM_CORES(NUM_CORES),
  .SET_W    (SET_W),
  .SMP_BITS (SMP_BITS),
  .SMP_PAT  (SMP_PAT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .epoch_end(epoch_end),
  .mode_excl(mode_excl),
  .aggr_fill(aggr_fill),
  .bypass   (bypass),
  .lk_set   (lk_set),
  .lk_excl  (lk_excl),
  .lk_ext   (lk_ext)
);

// File: tb/tb_incl_policy_sel.sv
module tb_incl_policy_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NC     = 2;
  localparam int SET_W  = 6;
  localparam int SB     = 3;
  localparam logic [SB-1:0] PAT = 3'b010;
  localparam int CW     = 8;
  localparam int DW     = CW + 1;
  localparam int CORE_W = 1;
  localparam int MAXC   = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [CORE_W-1:0] ev_core, lk_core;
  logic [SET_W-1:0]  ev_set, lk_set;
  logic ev_miss, ev_ins, epoch_end;
  logic signed [DW-1:0] perf_thr, ins_thr;
  logic [NC-1:0] mode_excl, aggr_fill, bypass;
  logic lk_excl, lk_ext;

  incl_policy_sel #(
    .NUM_CORES(NC), .SET_W(SET_W), .SMP_BITS(SB), .SMP_PAT(PAT), .CNT_W(CW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ev_core(ev_core), .ev_set(ev_set),
    .ev_miss(ev_miss), .ev_ins(ev_ins), .epoch_end(epoch_end),
    .perf_thr(perf_thr), .ins_thr(ins_thr),
    .mode_excl(mode_excl), .aggr_fill(aggr_fill), .bypass(bypass),
    .lk_core(lk_core), .lk_set(lk_set), .lk_excl(lk_excl), .lk_ext(lk_ext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nim[NC], exm[NC], nii[NC], exi[NC];
  bit em[NC], ea[NC], eb[NC];
  int pthr, ithr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int cls_of(logic [SET_W-1:0] s);
    if (s[SB-1:0] == PAT)  return 1;
    if (s[SB-1:0] == ~PAT) return 2;
    return 0;
  endfunction

  function automatic int sat(int v);
    return (v < MAXC) ? v + 1 : v;
  endfunction

  function automatic logic [SET_W-1:0] mk_set(int kind);
    logic [SET_W-1:0] s;
    s = SET_W'($urandom);
    if (kind == 1) s[SB-1:0] = PAT;
    else if (kind == 2) s[SB-1:0] = ~PAT;
    else if (cls_of(s) != 0) s[SB-1:0] = PAT + 3'd1;
    return s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, update the model at the edge, check after
  task automatic step(bit m, bit i, int core, logic [SET_W-1:0] s, bit ep, string ep_tag);
    ev_miss = m; ev_ins = i; ev_core = CORE_W'(core); ev_set = s; epoch_end = ep;
    perf_thr = DW'(pthr); ins_thr = DW'(ithr);
    @(posedge clk);
    if (ep) begin
      for (int c = 0; c < NC; c++) begin
        bit over;
        em[c] = (nim[c] - exm[c]) > pthr;
        over  = (exi[c] - nii[c]) > ithr;
        eb[c] = em[c] && over;
        ea[c] = !em[c] && !over;
        nim[c] = 0; exm[c] = 0; nii[c] = 0; exi[c] = 0;
      end
    end else begin
      int k;
      k = cls_of(s);
      if (k == 1) begin
        if (m) nim[core] = sat(nim[core]);
        if (i) nii[core] = sat(nii[core]);
      end else if (k == 2) begin
        if (m) exm[core] = sat(exm[core]);
        if (i) exi[core] = sat(exi[core]);
      end
    end
    @(negedge clk);
    ev_miss = 0; ev_ins = 0; epoch_end = 0;
    for (int c = 0; c < NC; c++) begin
      chk(ep ? {ep_tag, " mode"} : "R7 mode", int'(mode_excl[c]), int'(em[c]));
      chk(ep ? {ep_tag, " aggr"} : "R7 aggr", int'(aggr_fill[c]), int'(ea[c]));
      chk(ep ? {ep_tag, " byp"}  : "R7 byp",  int'(bypass[c]),    int'(eb[c]));
    end
    begin
      int lc, k;
      lc = $urandom % NC;
      lk_core = CORE_W'(lc);
      lk_set  = mk_set($urandom % 4);
      #1;
      k = cls_of(lk_set);
      // R2 classification drives the R3 lookup
      chk("R2/R3 lk_excl", int'(lk_excl), (k == 1) ? 0 : (k == 2) ? 1 : int'(em[lc]));
      chk("R2/R3 lk_ext",  int'(lk_ext),  (k != 0) ? 0 : (em[lc] ? int'(eb[lc]) : int'(ea[lc])));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; ev_miss = 0; ev_ins = 0; epoch_end = 0; ev_core = '0; ev_set = '0;
    perf_thr = '0; ins_thr = '0; lk_core = '0; lk_set = '0;
    pthr = 0; ithr = 0;
    for (int c = 0; c < NC; c++) begin
      nim[c] = 0; exm[c] = 0; nii[c] = 0; exi[c] = 0; em[c] = 0; ea[c] = 0; eb[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 mode", int'(mode_excl), 0);
    chk("R1 flags", int'({aggr_fill, bypass}), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", int'({mode_excl, aggr_fill, bypass}), 0);

    // R8: saturation of the non-inclusive miss counter, core 0
    pthr = MAXC - 1; ithr = 0;
    for (int n = 0; n < 300; n++) step(1, 0, 0, mk_set(1), 0, "");
    step(0, 0, 0, mk_set(0), 1, "R8");

    // R9: coincident event dropped, counters cleared
    pthr = -1;
    step(1, 0, 0, mk_set(1), 1, "R9");
    pthr = 0;
    step(1, 0, 0, mk_set(1), 1, "R9");
    step(0, 0, 0, mk_set(0), 1, "R9");

    // R5 equality boundary and R10 core isolation (events on core 1 only)
    pthr = 3;
    for (int n = 0; n < 5; n++) step(1, 0, 1, mk_set(1), 0, "");
    for (int n = 0; n < 2; n++) step(1, 0, 1, mk_set(2), 0, "");
    step(0, 0, 0, mk_set(0), 1, "R5/R10");
    pthr = 2;
    for (int n = 0; n < 5; n++) step(1, 0, 1, mk_set(1), 0, "");
    for (int n = 0; n < 2; n++) step(1, 0, 1, mk_set(2), 0, "");
    step(0, 0, 0, mk_set(0), 1, "R5/R10");

    // R11: negative thresholds
    pthr = -4; ithr = -2;
    for (int n = 0; n < 3; n++) step(1, 0, 0, mk_set(2), 0, "");
    for (int n = 0; n < 3; n++) step(0, 1, 0, mk_set(1), 0, "");
    step(0, 0, 0, mk_set(0), 1, "R11");

    // R4: follower events ignored
    pthr = 0; ithr = 0;
    for (int n = 0; n < 20; n++) step(1, 1, 0, mk_set(0), 0, "");
    step(0, 0, 0, mk_set(0), 1, "R4");

    // R6 extension variants and random mix
    for (int e = 0; e < 25; e++) begin
      int len;
      pthr = int'($urandom % 17) - 8;
      ithr = int'($urandom % 17) - 8;
      len  = 30 + int'($urandom % 50);
      for (int n = 0; n < len; n++)
        step(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % NC),
             mk_set($urandom % 4), 0, "");
      step(0, 0, 0, mk_set(0), 1, "R5/R6/R10");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule